// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block counts rendered lines within a video frame and raises an interrupt request when the count reaches a line number that the CPU has programmed. It sees two timing strobes from the display side. A frame-start pulse marks the frame boundary. A line pulse arrives once near the start of every visible line and of the prerender line. The CPU writes a target line and an enable bit, and reads a status byte. The status byte reports whether an interrupt is pending and whether the counter is inside a frame.

The counter is forced to zero on every frame-start pulse, whether the display is rendering or not. Stale counts therefore never carry into the next frame. When the target is 0 the interrupt is off. The interrupt output is a level. It follows an internal pending flag, and only a CPU read of the status register clears that flag.

A small state machine tracks the counter's phase. PH_IDLE means the count is zero. PH_RUN means it is counting. PH_SAT means it has reached its ceiling. The transitions are:
- PH_IDLE to PH_RUN on a line pulse.
- PH_RUN to PH_SAT on the line pulse that brings the count to all ones.
- Any state to PH_IDLE on a frame-start pulse.
- Otherwise the state holds.

Top module: `scanline_irq`

## Requirements
- R1: A frame-start pulse sets the counter to 0 at the next clock edge, whatever its earlier value and whatever the enable bit holds.
- R2: On a line pulse without a frame-start pulse, the pending flag is set if three conditions all hold: the enable bit is 1, the target is nonzero, and the counter equals the target. The counter then goes up by one. As a result, the pending flag first rises after target+1 line pulses following a frame start.
- R3: A target of 0 never sets the pending flag, however many line pulses arrive.
- R4: Status is read at address 2. Bit 7 holds the pending flag as it was before the access, and bits 5:0 read 0. The read clears the pending flag at the end of the access cycle.
- R5: Status bit 6 is 1 exactly when the counter is nonzero.
- R6: The irq output equals the pending flag. It stays high through idle cycles and through reads of other addresses until status is read.
- R7: The 8-bit counter saturates at 255 instead of wrapping. With the target at 255, every further line pulse sets the pending flag again.
- R8: Writing the enable bit to 0 leaves a pending flag set. While the enable bit is 0, no line pulse sets the flag.
- R9: When a frame-start pulse and a line pulse arrive in the same cycle, the frame-start reset wins. The counter becomes 0 and the pending flag is not set by that line pulse.
- R10: The register map is as follows. Address 0 holds the target, read and write, bits 7:0. Address 1 holds the enable bit, read and write, bit 0, with the other bits reading 0. Writes to address 2 (status) have no effect. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle frame boundary pulse |
| line_tick | input | 1 | One-cycle pulse per visible or prerender line |
| reg_wr | input | 1 | CPU register write strobe |
| reg_rd | input | 1 | CPU register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of reg_rd |
| irq | output | 1 | Interrupt request level |

## Verification
The counter value can only be seen through bit 6 of the status byte and through the line on which the interrupt fires. A wrong count, a missed reset or a wrapped counter therefore shows up as an interrupt that rises one or more line pulses early or late. The sweep over every target from 1 to 255 makes such an error visible within the frame in which it happens. A wrong pending-flag state shows at irq in the very next cycle. It also shows in bit 7 of the next status read, for example a flag that clears on its own or a flag that a disable or a simultaneous frame start fails to handle correctly.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_SAT  = 2'd2
    } phase_e;

    localparam logic [1:0] RA_TARGET = 2'd0;
    localparam logic [1:0] RA_CTRL   = 2'd1;
    localparam logic [1:0] RA_STATUS = 2'd2;
endpackage

// File: rtl/line_counter.sv
module line_counter
    import scanline_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             line_tick,
    input  logic [CNT_W-1:0] target,
    input  logic             enable,
    output logic             hit,
    output logic             in_frame
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - 1'b1;

    phase_e           phase, phase_nxt;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nxt;
    end

    always_comb begin
        phase_nxt = phase;
        if (frame_start) begin
            phase_nxt = PH_IDLE;
        end else if (line_tick) begin
            unique case (phase)
                PH_IDLE: phase_nxt = PH_RUN;
                PH_RUN:  phase_nxt = (count == CNT_PRE) ? PH_SAT : PH_RUN;
                PH_SAT:  phase_nxt = PH_SAT;
                default: phase_nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          count <= '0;
        else if (frame_start)                count <= '0;
        else if (line_tick && phase != PH_SAT) count <= count + 1'b1;
    end

    always_comb begin
        in_frame = (phase != PH_IDLE);
        hit      = line_tick && !frame_start && enable
                   && (target != '0) && (count == target);
    end

    // R1
    frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (count == '0));
    // R2
    tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && !frame_start && count != CNT_MAX)
        |=> (count == CNT_W'($past(count) + 1'b1)));
    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && !frame_start && count == CNT_MAX) |=> (count == CNT_MAX));
    // R5
    phase_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) == (count == '0));
endmodule

// File: rtl/pend_flag.sv
module pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (!rst_n)   pending <= 1'b0;
        else if (set) pending <= 1'b1;
        else if (ack) pending <= 1'b0;
    end

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |=> pending);
    // R4
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set) |=> !pending);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import scanline_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              pending,
    input  logic              in_frame,
    output logic [CNT_W-1:0]  target,
    output logic              enable,
    output logic              ack,
    output logic [DATA_W-1:0] reg_rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= '0;
            enable <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == RA_TARGET) target <= reg_wdata[CNT_W-1:0];
            if (reg_addr == RA_CTRL)   enable <= reg_wdata[0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_TARGET: reg_rdata[CNT_W-1:0] = target;
            RA_CTRL:   reg_rdata[0] = enable;
            RA_STATUS: begin
                reg_rdata[DATA_W-1] = pending;
                reg_rdata[DATA_W-2] = in_frame;
            end
            default:   reg_rdata = '0;
        endcase
        ack = reg_rd && (reg_addr == RA_STATUS);
    end

    // R3
    zero_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (target == '0 && !pending) |=> !pending);
endmodule

// File: rtl/scanline_irq.sv
module scanline_irq #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_tick,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] target;
    logic             enable, hit, in_frame, pending, ack;

    irq_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pending(pending),
        .in_frame(in_frame), .target(target), .enable(enable),
        .ack(ack), .reg_rdata(reg_rdata)
    );

    line_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_tick(line_tick), .target(target), .enable(enable),
        .hit(hit), .in_frame(in_frame)
    );

    pend_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set(hit), .ack(ack), .pending(pending)
    );

    assign irq = pending;

    // R9
    frame_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !irq && !ack) |=> !irq);
    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !irq) |=> !irq);
endmodule

// File: tb/tb_scanline_irq.sv
module tb_scanline_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0, line_tick = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;
    logic [7:0] rv;

    scanline_irq dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_tick(line_tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tick();
        line_tick = 1'b1;
        @(negedge clk);
        line_tick = 1'b0;
    endtask

    task automatic frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("reset irq", irq, 0);
        rd(2'd2, rv); chk("R4 reset status", rv, 8'h00);
        rd(2'd0, rv); chk("R10 reset target", rv, 8'h00);
        rd(2'd1, rv); chk("R10 reset ctrl", rv, 8'h00);

        // R10 register map
        wr(2'd0, 8'hA5); rd(2'd0, rv); chk("R10 target rw", rv, 8'hA5);
        wr(2'd1, 8'hFF); rd(2'd1, rv); chk("R10 ctrl bit0 only", rv, 8'h01);
        wr(2'd2, 8'hFF); rd(2'd2, rv); chk("R10 status write ignored", rv, 8'h00);
        chk("R10 status write no irq", irq, 0);
        rd(2'd3, rv); chk("R10 addr3 zero", rv, 8'h00);

        // R2 sweep of every nonzero target
        for (int t = 1; t < 256; t++) begin
            wr(2'd0, 8'(t));
            frame();
            repeat (t) tick();
            chk("R2 no early irq", irq, 0);
            tick();
            chk("R2 irq at target+1", irq, 1);
            rd(2'd2, rv); chk("R4 status pend+inframe", rv, 8'hC0);
            chk("R4 irq cleared by read", irq, 0);
        end

        // R7 saturation: counter holds 255, so target 255 matches again
        tick();
        chk("R7 saturated refire", irq, 1);
        rd(2'd2, rv); chk("R7 status at saturation", rv, 8'hC0);
        repeat (10) tick();
        chk("R7 still matching", irq, 1);
        rd(2'd2, rv);

        // R3 target zero never fires
        wr(2'd0, 8'd0);
        frame();
        repeat (300) tick();
        chk("R3 target zero quiet", irq, 0);
        rd(2'd2, rv); chk("R5 in-frame when saturated", rv, 8'h40);

        // R1 frame reset, with enable off as well
        wr(2'd1, 8'd0);
        frame();
        rd(2'd2, rv); chk("R1 frame clears count", rv, 8'h00);
        tick();
        rd(2'd2, rv); chk("R5 in-frame after one line", rv, 8'h40);
        wr(2'd1, 8'd1);
        wr(2'd0, 8'd3);
        frame();
        repeat (2) tick();
        frame();
        repeat (3) tick();
        chk("R1 restart no early irq", irq, 0);
        tick();
        chk("R1 restart fires at 4th line", irq, 1);

        // R6 level holds
        repeat (50) @(negedge clk);
        chk("R6 irq holds idle", irq, 1);
        rd(2'd0, rv); rd(2'd1, rv); rd(2'd3, rv);
        chk("R6 other reads keep irq", irq, 1);

        // R8 disable keeps pending; disabled lines do not set
        wr(2'd1, 8'd0);
        chk("R8 disable keeps pending", irq, 1);
        rd(2'd2, rv); chk("R8 status after disable", rv, 8'hC0);
        wr(2'd0, 8'd2);
        frame();
        repeat (5) tick();
        chk("R8 disabled no set", irq, 0);
        wr(2'd1, 8'd1);

        // R9 frame wins over simultaneous line pulse
        wr(2'd0, 8'd1);
        frame();
        tick();
        frame_start = 1'b1; line_tick = 1'b1;
        @(negedge clk);
        frame_start = 1'b0; line_tick = 1'b0;
        chk("R9 no irq on collision", irq, 0);
        rd(2'd2, rv); chk("R9 counter zero after collision", rv, 8'h00);
        tick(); tick();
        chk("R9 fires after restart", irq, 1);
        rd(2'd2, rv);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule